// File: doc/BRIEF.md
# CAN Loopback Pin Router

This block sits between a CAN protocol engine and the transceiver pins. It decides where the engine's transmit bit goes and where the engine's receive bit comes from. There are four operating modes, selected by a loopback-enable bit and a bus-monitoring bit. In normal operation the engine drives the bus and listens to it. Bus monitoring keeps the transmit pin silent and still lets the engine listen. External loopback feeds the engine's own transmit stream back into its receiver and still drives it onto the pin, so the traffic can be watched. Internal loopback also feeds the stream back, but holds the pin recessive and ignores the bus, so a node can test itself while a live network keeps running.

Both loopback modes raise a mask that tells the engine not to report an acknowledge error. With no other node on the wire, the acknowledge slot reads recessive. The mode configuration is adopted only while the engine reports that it is idle, so a frame in flight never changes routing. The receive pin passes through a parameterised synchroniser. Both pin-side outputs are registered.

Top module: `can_loopback_pinctl`

## Requirements
- R1: While `rst` is high, `tx_pin_o` and `eng_rx_o` are 1 (recessive), `ack_err_mask_o` is 0, and the active mode becomes normal.
- R2: In normal mode (active code 2'b00), `tx_pin_o` equals `eng_tx_i` from one clock earlier, and `eng_rx_o` equals `rx_pin_i` from SYNC_STAGES+1 clocks earlier.
- R3: In bus-monitoring mode (active code 2'b01, loopback 0 and monitor 1), `tx_pin_o` is held at 1 and `eng_rx_o` follows `rx_pin_i` with the same latency as in R2.
- R4: In external loopback (active code 2'b10, loopback 1 and monitor 0), `tx_pin_o` and `eng_rx_o` both equal `eng_tx_i` from one clock earlier, and `rx_pin_i` has no effect on `eng_rx_o`.
- R5: In internal loopback (active code 2'b11, both bits 1), `tx_pin_o` is held at 1, `eng_rx_o` equals `eng_tx_i` from one clock earlier, and `rx_pin_i` has no effect on `eng_rx_o`.
- R6: `ack_err_mask_o` is 1 exactly when the active mode is one of the two loopback modes. The active code is {`cfg_loop_i`, `cfg_mon_i`}, taken as last adopted.
- R7: The active mode takes on {`cfg_loop_i`, `cfg_mon_i`} only at a clock edge where `eng_idle_i` is 1. `ack_err_mask_o` changes at that edge. The pin outputs use the new mode from the next edge on.
- R8: The receive synchroniser keeps running in the loopback modes. After a return to normal, `eng_rx_o` at once shows the pin value from SYNC_STAGES+1 clocks earlier, not stale data.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| eng_tx_i | input | 1 | Transmit bit from the protocol engine |
| rx_pin_i | input | 1 | Receive pin from the transceiver |
| cfg_loop_i | input | 1 | Loopback-enable configuration bit |
| cfg_mon_i | input | 1 | Bus-monitoring configuration bit |
| eng_idle_i | input | 1 | Engine is idle or initialising; the mode may be updated |
| tx_pin_o | output | 1 | Registered transmit pin |
| eng_rx_o | output | 1 | Registered receive bit to the engine |
| ack_err_mask_o | output | 1 | Suppress acknowledge-error reporting |

## Verification
Random streams on the engine transmit bit and the receive pin are chosen independently of each other. This tells the loopback modes, which must track only the transmit bit, apart from normal and monitoring, which must track only the pin and its longer latency. The configuration bits change at random while the idle qualifier is random too, so updates that are blocked have to be told apart from updates that are adopted. Directed cases hold a dominant receive pin during internal loopback, request a mode while the engine is busy, and toggle the pin during loopback just before a return to normal. This last case shows whether the synchroniser kept running.

// File: rtl/can_lb_pkg.sv
package can_lb_pkg;

  typedef enum logic [1:0] {
    LB_NORMAL   = 2'b00,
    LB_MONITOR  = 2'b01,
    LB_EXTERNAL = 2'b10,
    LB_INTERNAL = 2'b11
  } lb_mode_e;

  localparam logic RECESSIVE = 1'b1;

  function automatic lb_mode_e lb_decode(input logic loop_en, input logic mon_en);
    return lb_mode_e'({loop_en, mon_en});
  endfunction

  function automatic logic lb_is_loop(input lb_mode_e m);
    return (m == LB_EXTERNAL) || (m == LB_INTERNAL);
  endfunction

  function automatic logic lb_tx_silent(input lb_mode_e m);
    return (m == LB_MONITOR) || (m == LB_INTERNAL);
  endfunction

endpackage

// File: rtl/can_lb_mode_ctl.sv
module can_lb_mode_ctl
  import can_lb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     cfg_loop,
  input  logic     cfg_mon,
  input  logic     eng_idle,
  output lb_mode_e mode_q,
  output logic     loop_q
);

  lb_mode_e mode_d;

  always_comb begin
    mode_d = mode_q;
    if (eng_idle) mode_d = lb_decode(cfg_loop, cfg_mon);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q <= LB_NORMAL;
      loop_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      loop_q <= lb_is_loop(mode_d);
    end
  end

  // R7: a busy engine freezes the active mode
  a_r7_hold_while_busy: assert property (@(posedge clk) disable iff (rst)
    !eng_idle |=> $stable(mode_q));

  // R7: an idle edge adopts the requested configuration
  a_r7_adopt_when_idle: assert property (@(posedge clk) disable iff (rst)
    eng_idle |=> mode_q == lb_decode($past(cfg_loop), $past(cfg_mon)));

endmodule

// File: rtl/can_lb_rx_sync.sv
module can_lb_rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);

  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= d;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], d};
      end
    end
  endgenerate

  assign q = chain[STAGES-1];

endmodule

// File: rtl/can_lb_route.sv
module can_lb_route
  import can_lb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  lb_mode_e mode,
  input  logic     eng_tx,
  input  logic     rx_synced,
  output logic     tx_pin_q,
  output logic     eng_rx_q
);

  logic tx_d, rx_d;

  always_comb begin
    tx_d = lb_tx_silent(mode) ? RECESSIVE : eng_tx;
    rx_d = lb_is_loop(mode) ? eng_tx : rx_synced;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_pin_q <= RECESSIVE;
      eng_rx_q <= RECESSIVE;
    end else begin
      tx_pin_q <= tx_d;
      eng_rx_q <= rx_d;
    end
  end

  // R5: internal loopback keeps the bus pin recessive
  a_r5_internal_silent: assert property (@(posedge clk) disable iff (rst)
    (mode == LB_INTERNAL) |=> tx_pin_q == RECESSIVE);

  // R3: monitoring keeps the bus pin recessive
  a_r3_monitor_silent: assert property (@(posedge clk) disable iff (rst)
    (mode == LB_MONITOR) |=> tx_pin_q == RECESSIVE);

  // R4: loopback returns the engine's own bit
  a_r4_loop_feedback: assert property (@(posedge clk) disable iff (rst)
    lb_is_loop(mode) |=> eng_rx_q == $past(eng_tx));

endmodule

// File: rtl/can_loopback_pinctl.sv
module can_loopback_pinctl
  import can_lb_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic eng_tx_i,
  input  logic rx_pin_i,
  input  logic cfg_loop_i,
  input  logic cfg_mon_i,
  input  logic eng_idle_i,
  output logic tx_pin_o,
  output logic eng_rx_o,
  output logic ack_err_mask_o
);

  lb_mode_e mode_q;
  logic     loop_q;
  logic     rx_synced;

  can_lb_mode_ctl u_mode (
    .clk      (clk),
    .rst      (rst),
    .cfg_loop (cfg_loop_i),
    .cfg_mon  (cfg_mon_i),
    .eng_idle (eng_idle_i),
    .mode_q   (mode_q),
    .loop_q   (loop_q)
  );

  can_lb_rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   (rx_pin_i),
    .q   (rx_synced)
  );

  can_lb_route u_route (
    .clk       (clk),
    .rst       (rst),
    .mode      (mode_q),
    .eng_tx    (eng_tx_i),
    .rx_synced (rx_synced),
    .tx_pin_q  (tx_pin_o),
    .eng_rx_q  (eng_rx_o)
  );

  assign ack_err_mask_o = loop_q;

  // R6: the mask can only rise after an idle edge that requested loopback
  a_r6_mask_rise_source: assert property (@(posedge clk) disable iff (rst)
    $rose(ack_err_mask_o) |-> $past(cfg_loop_i && eng_idle_i));

  // R6: the mask agrees with the mode register in the control module
  a_r6_mask_matches_mode: assert property (@(posedge clk) disable iff (rst)
    ack_err_mask_o == mode_q[1]);

  // R2: normal mode drives the pin from the engine
  a_r2_normal_tx: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_NORMAL) |=> tx_pin_o == $past(eng_tx_i));

  // R4: external loopback still shows the stream on the pin
  a_r4_external_tx: assert property (@(posedge clk) disable iff (rst)
    (mode_q == LB_EXTERNAL) |=> tx_pin_o == $past(eng_tx_i));

endmodule

// File: tb/can_loopback_pinctl_test.sv
module can_loopback_pinctl_test;

  localparam int SYNC = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic eng_tx = 1'b1, rx_pin = 1'b1, cfg_loop = 1'b0, cfg_mon = 1'b0, idle = 1'b0;
  logic tx_pin, eng_rx, mask;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 0;

  // bench reference state
  logic [1:0]      m_mode = 2'b00;
  logic [SYNC-1:0] m_chain = '1;
  logic            e_tx = 1'b1, e_rx = 1'b1, e_mask = 1'b0;
  logic [1:0]      used_mode = 2'b00;

  always #2.5 clk = ~clk;

  can_loopback_pinctl #(.SYNC_STAGES(SYNC)) uut (
    .clk(clk), .rst(rst), .eng_tx_i(eng_tx), .rx_pin_i(rx_pin),
    .cfg_loop_i(cfg_loop), .cfg_mon_i(cfg_mon), .eng_idle_i(idle),
    .tx_pin_o(tx_pin), .eng_rx_o(eng_rx), .ack_err_mask_o(mask)
  );

  task automatic chk(input string tag, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic string mode_tag(input logic [1:0] m);
    case (m)
      2'b00:   return "R2";
      2'b01:   return "R3";
      2'b10:   return "R4";
      default: return "R5";
    endcase
  endfunction

  function automatic logic exp_tx_f(input logic [1:0] m, input logic t);
    return (m == 2'b01 || m == 2'b11) ? 1'b1 : t;
  endfunction

  // one clock: advance reference from requirements, then compare
  task automatic step();
    used_mode = m_mode;
    e_tx = exp_tx_f(m_mode, eng_tx);
    e_rx = m_mode[1] ? eng_tx : m_chain[SYNC-1];
    m_chain = {m_chain[SYNC-2:0], rx_pin};
    if (idle) m_mode = {cfg_loop, cfg_mon};
    e_mask = m_mode[1];
    @(posedge clk);
    #1;
    chk(mode_tag(used_mode), tx_pin, e_tx);
    chk(mode_tag(used_mode), eng_rx, e_rx);
    chk("R6", mask, e_mask);
  endtask

  task automatic set_in(input logic t, input logic r, input logic l,
                        input logic mo, input logic i);
    eng_tx = t; rx_pin = r; cfg_loop = l; cfg_mon = mo; idle = i;
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog: actual=running expected=done");
    summary();
  end

  initial begin : main
    void'($urandom(32'h5EED_C0DE));
    // R1: reset state
    set_in(1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
    repeat (4) begin
      @(posedge clk);
      #1;
      chk("R1", tx_pin, 1'b1);
      chk("R1", eng_rx, 1'b1);
      chk("R1", mask, 1'b0);
    end
    rst = 1'b0;
    set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);

    // R7: request internal loopback while the engine is busy
    for (int i = 0; i < 6; i++) begin
      set_in(i[0], ~i[0], 1'b1, 1'b1, 1'b0);
      step();
      chk("R7", mask, 1'b0);
      chk("R7", tx_pin, i[0]);
    end
    set_in(1'b0, 1'b1, 1'b1, 1'b1, 1'b1);
    step();
    chk("R7", mask, 1'b1);
    chk("R7", tx_pin, 1'b0); // still old (normal) routing at this edge

    // R5: dominant receive pin must not reach engine; pin stays recessive
    for (int i = 0; i < 8; i++) begin
      set_in(i[1], 1'b0, 1'b1, 1'b1, 1'b0);
      step();
      chk("R5", tx_pin, 1'b1);
      chk("R5", eng_rx, i[1]);
    end

    // R8: toggle pin in external loopback, then return to normal
    set_in(1'b1, 1'b0, 1'b1, 1'b0, 1'b1);
    step();
    for (int i = 0; i < 6; i++) begin
      set_in(1'b1, i[0], 1'b1, 1'b0, 1'b0);
      step();
      chk("R4", eng_rx, 1'b1);
    end
    set_in(1'b1, 1'b0, 1'b0, 1'b0, 1'b1);
    step(); // mode becomes normal at this edge
    set_in(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
    step(); // first normal-routed output: pin value from SYNC+1 edges earlier (1)
    chk("R8", eng_rx, 1'b1);
    step();
    chk("R8", eng_rx, 1'b0);

    // random mix over all modes
    for (int i = 0; i < 4000; i++) begin
      set_in($urandom_range(1), $urandom_range(1), $urandom_range(1),
             $urandom_range(1), ($urandom_range(3) == 0));
      step();
    end

    // R2 / R3 directed latency on a single pulse
    set_in(1'b1, 1'b1, 1'b0, 1'b1, 1'b1);
    step();
    set_in(1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
    step();
    chk("R3", tx_pin, 1'b1);
    set_in(1'b1, 1'b1, 1'b0, 1'b1, 1'b0);
    step();
    step();
    chk("R3", eng_rx, 1'b0);
    summary();
  end

endmodule